// File: doc/BRIEF.md
# Burst SRAM Access Cycle Decoder

This block sits behind the control pins of a synchronous burst SRAM and decides, on every rising clock edge, what the memory does in that cycle. The inputs are three chip selects of mixed polarity, two address strobes, a burst-step input, a global write, a byte-write enable and one select per byte lane. From these the block classifies the cycle as one of five kinds: deselect, begin read, begin write, continue read or continue write. It chooses whether the external address, the stepped burst address or the held address is used. It also produces per-lane write strobes into a small word array held inside the block.

Reads return the addressed word through a single output register. The shared data bus is modelled as a separate read-data port and a drive-enable output. The drive enable follows the read-enable pin combinationally. It is also forced low as soon as the pins being presented describe a write, so bus turnaround needs no extra idle cycle. The burst step increments only the two lowest address bits and wraps within an aligned group of four words.

Top module: `burst_cycle_dec`

## Requirements
- R1: While reset is held low, the cycle code reads 0 (deselect), the address output reads 0 and the bus drive enable is low.
- R2: When the primary strobe is low and the primary select is low, the cycle is a deselect (code 0) if the active-low select is high or the active-high select is low. Otherwise it begins a read (code 1) at the external address, and the write enables and write data have no effect.
- R3: When the primary select is high and the secondary strobe is low, the cycle is a deselect (code 0) whatever the primary strobe does. While the primary select is high, the primary strobe is ignored.
- R4: When the secondary strobe is low and the primary strobe is not in effect, a valid selection begins a write (code 2) at the external address if any lane is enabled for writing, and begins a read (code 1) otherwise. An invalid selection gives a deselect.
- R5: With both strobes inactive and the step input low, an active burst continues at the next address. The address's two low bits go up by one modulo 4 and its upper bits are kept. The code is 4 (continue write) if any lane is enabled for writing and 3 (continue read) otherwise. After a deselect, a step keeps the block deselected.
- R6: With both strobes inactive and the step input high, the address and the cycle code keep their previous values.
- R7: A low global write enables all four byte lanes, regardless of the byte-write enable and the lane selects.
- R8: With global write high and the byte-write enable low, only lanes whose select bit is low are written (lane i is data bits 8i+7..8i), and the other lanes keep their contents. With the byte-write enable high, no lane is written.
- R9: After the edge that starts or continues a read, the read-data port shows the word stored at that cycle's address.
- R10: The bus drive enable is high only while the registered cycle is a read, the read-enable pin is low, and the pins presented now do not decode as a write. It follows the read-enable pin without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_pri_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Tertiary chip select, active low |
| strb_a_n | input | 1 | Primary address strobe, active low |
| strb_b_n | input | 1 | Secondary address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Byte lane selects, active low |
| rd_en_n | input | 1 | Read enable for the bus, active low, not clocked |
| addr_i | input | AW | External word address |
| wdata_i | input | LANES*LW | Write data from the bus |
| rdata_o | output | LANES*LW | Registered read data |
| bus_drive_o | output | 1 | Data bus drive enable |
| cyc_o | output | 3 | Registered cycle code (0 deselect, 1 begin read, 2 begin write, 3 continue read, 4 continue write) |
| addr_o | output | AW | Address used by the current cycle |

## Verification
The hardest situation to reach is a primary strobe that arrives while the primary select is high in the middle of a read burst. In that case the decoder must step the burst and not deselect or restart. The bench builds a four-word burst first and raises that strobe on one step, so the wrapped address sequence and the returned data show that the strobe was ignored. The bench also exercises the drive enable between clock edges: it toggles the read-enable pin mid-cycle and then presents write pins during a held read, checking the enable before the next edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_RD_NEW = 3'd1,
        CYC_WR_NEW = 3'd2,
        CYC_RD_NXT = 3'd3,
        CYC_WR_NXT = 3'd4
    } cyc_e;

    typedef enum logic [1:0] {
        ASEL_HOLD = 2'd0,
        ASEL_EXT  = 2'd1,
        ASEL_STEP = 2'd2
    } asel_e;

    function automatic logic cyc_is_rd(cyc_e c);
        return (c == CYC_RD_NEW) || (c == CYC_RD_NXT);
    endfunction

    function automatic logic cyc_is_wr(cyc_e c);
        return (c == CYC_WR_NEW) || (c == CYC_WR_NXT);
    endfunction

endpackage

// File: rtl/bcd_lanes.sv
module bcd_lanes #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !wr_all_n || (!wr_byte_n && !lane_sel_n[g]);
    end
endmodule

// File: rtl/bcd_decode.sv
module bcd_decode
    import bcd_pkg::*;
(
    input  logic  sel_pri_n,
    input  logic  sel_hi,
    input  logic  sel_lo_n,
    input  logic  strb_a_n,
    input  logic  strb_b_n,
    input  logic  step_n,
    input  logic  wr_req,
    input  cyc_e  prev,
    output cyc_e  cyc_nx,
    output asel_e asel,
    output logic  do_wr,
    output logic  do_rd
);
    logic sel_ok;
    logic active;

    assign sel_ok = !sel_pri_n && sel_hi && !sel_lo_n;
    assign active = (prev != CYC_IDLE);

    always_comb begin
        cyc_nx = prev;
        asel   = ASEL_HOLD;
        if (!sel_pri_n && !strb_a_n) begin
            // primary strobe: always a read, write pins disregarded
            if (sel_ok) begin
                cyc_nx = CYC_RD_NEW;
                asel   = ASEL_EXT;
            end else begin
                cyc_nx = CYC_IDLE;
            end
        end else if (!strb_b_n) begin
            if (sel_ok) begin
                cyc_nx = wr_req ? CYC_WR_NEW : CYC_RD_NEW;
                asel   = ASEL_EXT;
            end else begin
                cyc_nx = CYC_IDLE;
            end
        end else if (!step_n) begin
            if (active) begin
                cyc_nx = wr_req ? CYC_WR_NXT : CYC_RD_NXT;
                asel   = ASEL_STEP;
            end else begin
                cyc_nx = CYC_IDLE;
            end
        end
    end

    assign do_wr = cyc_is_wr(cyc_nx) && wr_req;
    assign do_rd = cyc_is_rd(cyc_nx);
endmodule

// File: rtl/bcd_bank.sv
module bcd_bank #(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rword
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                store[addr] <= wdata[g*LW +: LW];
            end
        end

        assign rword[g*LW +: LW] = store[addr];
    end
endmodule

// File: rtl/burst_cycle_dec.sv
module burst_cycle_dec
    import bcd_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_pri_n,
    input  logic                sel_hi,
    input  logic                sel_lo_n,
    input  logic                strb_a_n,
    input  logic                strb_b_n,
    input  logic                step_n,
    input  logic                wr_all_n,
    input  logic                wr_byte_n,
    input  logic [LANES-1:0]    lane_sel_n,
    input  logic                rd_en_n,
    input  logic [AW-1:0]       addr_i,
    input  logic [LANES*LW-1:0] wdata_i,
    output logic [LANES*LW-1:0] rdata_o,
    output logic                bus_drive_o,
    output logic [2:0]          cyc_o,
    output logic [AW-1:0]       addr_o
);
    localparam int DW    = LANES * LW;
    localparam int CNT_W = 2;

    typedef struct packed {
        cyc_e          cyc;
        logic [AW-1:0] addr;
        logic [DW-1:0] rdata;
    } st_t;

    st_t            st_d, st_q;
    cyc_e           dec_cyc;
    asel_e          dec_sel;
    logic           dec_wr, dec_rd;
    logic [LANES-1:0] lane_en, bank_we;
    logic [AW-1:0]  step_addr, acc_addr;
    logic [DW-1:0]  bank_word;

    bcd_lanes #(.LANES(LANES)) u_lanes (
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .lane_en    (lane_en)
    );

    bcd_decode u_dec (
        .sel_pri_n (sel_pri_n),
        .sel_hi    (sel_hi),
        .sel_lo_n  (sel_lo_n),
        .strb_a_n  (strb_a_n),
        .strb_b_n  (strb_b_n),
        .step_n    (step_n),
        .wr_req    (|lane_en),
        .prev      (st_q.cyc),
        .cyc_nx    (dec_cyc),
        .asel      (dec_sel),
        .do_wr     (dec_wr),
        .do_rd     (dec_rd)
    );

    assign step_addr = {st_q.addr[AW-1:CNT_W],
                        st_q.addr[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1}};

    always_comb begin
        case (dec_sel)
            ASEL_EXT:  acc_addr = addr_i;
            ASEL_STEP: acc_addr = step_addr;
            default:   acc_addr = st_q.addr;
        endcase
    end

    assign bank_we = lane_en & {LANES{dec_wr}};

    bcd_bank #(.AW(AW), .LANES(LANES), .LW(LW)) u_bank (
        .clk   (clk),
        .we    (bank_we),
        .addr  (acc_addr),
        .wdata (wdata_i),
        .rword (bank_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cyc  = dec_cyc;
        st_d.addr = acc_addr;
        if (dec_rd) begin
            st_d.rdata = bank_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cyc: CYC_IDLE, addr: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_o       = st_q.cyc;
    assign addr_o      = st_q.addr;
    assign rdata_o     = st_q.rdata;
    assign bus_drive_o = cyc_is_rd(st_q.cyc) && !rd_en_n && !dec_wr;
endmodule

// File: rtl/bcd_chk.sv
module bcd_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_pri_n,
    input logic          sel_hi,
    input logic          sel_lo_n,
    input logic          strb_a_n,
    input logic          strb_b_n,
    input logic          step_n,
    input logic          rd_en_n,
    input logic [AW-1:0] addr_i,
    input logic [2:0]    cyc_o,
    input logic [AW-1:0] addr_o,
    input logic          bus_drive_o
);
    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (cyc_o == 3'd0 && addr_o == '0 && !bus_drive_o);
        end
    end

    // R2
    prim_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_pri_n && !strb_a_n && sel_hi && !sel_lo_n)
        |=> (cyc_o == 3'd1 && addr_o == $past(addr_i)));

    // R3
    sec_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pri_n && !strb_b_n) |=> (cyc_o == 3'd0));

    // R5
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_a_n || sel_pri_n) && strb_b_n && !step_n && cyc_o != 3'd0)
        |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1
             && addr_o[AW-1:2] == $past(addr_o[AW-1:2])));

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_a_n || sel_pri_n) && strb_b_n && step_n)
        |=> ($stable(addr_o) && $stable(cyc_o)));

    // R10
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> !rd_en_n);
endmodule

bind burst_cycle_dec bcd_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_pri_n   (sel_pri_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .strb_a_n    (strb_a_n),
    .strb_b_n    (strb_b_n),
    .step_n      (step_n),
    .rd_en_n     (rd_en_n),
    .addr_i      (addr_i),
    .cyc_o       (cyc_o),
    .addr_o      (addr_o),
    .bus_drive_o (bus_drive_o)
);

// File: tb/sim_burst_cycle_dec.sv
`timescale 1ns/100ps
module sim_burst_cycle_dec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_pri_n, sel_hi, sel_lo_n;
    logic        strb_a_n, strb_b_n, step_n;
    logic        wr_all_n, wr_byte_n;
    logic [3:0]  lane_sel_n;
    logic        rd_en_n;
    logic [3:0]  addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        bus_drive_o;
    logic [2:0]  cyc_o;
    logic [3:0]  addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    burst_cycle_dec u0 (
        .clk(clk), .rst_n(rst_n), .sel_pri_n(sel_pri_n), .sel_hi(sel_hi),
        .sel_lo_n(sel_lo_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_sel_n(lane_sel_n), .rd_en_n(rd_en_n), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .bus_drive_o(bus_drive_o),
        .cyc_o(cyc_o), .addr_o(addr_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic [2:0] c,
                                input logic [3:0] a);
        check(cyc_o == c, req, "cycle code", {29'd0, cyc_o}, {29'd0, c});
        check(addr_o == a, req, "address", {28'd0, addr_o}, {28'd0, a});
    endtask

    task automatic expect_data(input string req, input logic [31:0] d);
        check(rdata_o == d, req, "read data", rdata_o, d);
    endtask

    task automatic expect_drive(input string req, input logic e);
        check(bus_drive_o == e, req, "bus drive", {31'd0, bus_drive_o}, {31'd0, e});
    endtask

    task automatic idle();
        sel_pri_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0;
        strb_a_n = 1'b1; strb_b_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
        rd_en_n = 1'b0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic begin_sec(input logic [3:0] a, input logic [31:0] d);
        idle();
        sel_pri_n = 1'b0; strb_b_n = 1'b0; addr_i = a; wdata_i = d;
    endtask

    task automatic begin_pri(input logic [3:0] a);
        idle();
        sel_pri_n = 1'b0; strb_a_n = 1'b0; addr_i = a;
    endtask

    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        expect_state("R1", 3'd0, 4'd0);
        expect_drive("R1", 1'b0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_global_write();
        begin_sec(4'd4, 32'hA1B2C3D4);
        wr_all_n = 1'b0; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
        tick();
        expect_state("R4", 3'd2, 4'd4);
        expect_drive("R10", 1'b0);
        idle(); tick();
        begin_sec(4'd4, 32'h0);
        tick();
        expect_state("R4", 3'd1, 4'd4);
        expect_data("R7", 32'hA1B2C3D4);
        expect_drive("R9", 1'b1);
        idle(); tick();
    endtask

    task automatic t_byte_write();
        begin_sec(4'd4, 32'h11223344);
        wr_byte_n = 1'b0; lane_sel_n = 4'b1010;
        tick();
        expect_state("R8", 3'd2, 4'd4);
        begin_sec(4'd4, 32'hFFFFFFFF);
        wr_byte_n = 1'b1; lane_sel_n = 4'b0000;
        tick();
        expect_state("R8", 3'd1, 4'd4);
        expect_data("R8", 32'hA122C344);
        idle(); tick();
    endtask

    task automatic t_primary_ignores_write();
        begin_pri(4'd4);
        wr_all_n = 1'b0; wdata_i = 32'hFFFFFFFF;
        tick();
        expect_state("R2", 3'd1, 4'd4);
        expect_data("R2", 32'hA122C344);
        idle(); tick();
        expect_state("R6", 3'd1, 4'd4);
        expect_data("R2", 32'hA122C344);
    endtask

    task automatic t_deselect();
        idle(); sel_pri_n = 1'b1; strb_a_n = 1'b0; strb_b_n = 1'b0;
        tick();
        check(cyc_o == 3'd0, "R3", "deselect with secondary strobe", {29'd0, cyc_o}, 32'd0);
        expect_drive("R3", 1'b0);
        idle(); step_n = 1'b0;
        tick();
        check(cyc_o == 3'd0, "R5", "step after deselect", {29'd0, cyc_o}, 32'd0);
        begin_sec(4'd4, 32'h0); tick();
        begin_pri(4'd4); sel_lo_n = 1'b1;
        tick();
        check(cyc_o == 3'd0, "R2", "low select inactive", {29'd0, cyc_o}, 32'd0);
        begin_sec(4'd4, 32'h0); tick();
        begin_pri(4'd4); sel_hi = 1'b0;
        tick();
        check(cyc_o == 3'd0, "R2", "high select inactive", {29'd0, cyc_o}, 32'd0);
        begin_sec(4'd4, 32'h0); tick();
        begin_sec(4'd4, 32'h55555555); sel_hi = 1'b0; wr_all_n = 1'b0;
        tick();
        check(cyc_o == 3'd0, "R4", "invalid select", {29'd0, cyc_o}, 32'd0);
        begin_sec(4'd4, 32'h0); tick();
        expect_data("R4", 32'hA122C344);
        idle(); tick();
    endtask

    task automatic t_burst_write();
        begin_sec(4'd8, 32'h100);
        wr_all_n = 1'b0;
        tick();
        expect_state("R5", 3'd2, 4'd8);
        for (int i = 1; i < 4; i++) begin
            idle(); step_n = 1'b0; wr_all_n = 1'b0; wdata_i = 32'h100 + i;
            tick();
            expect_state("R5", 3'd4, 4'(8 + i));
        end
        idle(); tick();
    endtask

    task automatic t_burst_read();
        begin_pri(4'd10);
        tick();
        expect_state("R9", 3'd1, 4'd10);
        expect_data("R9", 32'h102);
        idle(); step_n = 1'b0; strb_a_n = 1'b0;
        tick();
        expect_state("R3", 3'd3, 4'd11);
        expect_data("R3", 32'h103);
        idle(); step_n = 1'b0;
        tick();
        expect_state("R5", 3'd3, 4'd8);
        expect_data("R5", 32'h100);
        idle(); step_n = 1'b0;
        tick();
        expect_state("R5", 3'd3, 4'd9);
        expect_data("R9", 32'h101);
    endtask

    task automatic t_hold();
        idle();
        tick();
        expect_state("R6", 3'd3, 4'd9);
        expect_data("R6", 32'h101);
        tick();
        expect_state("R6", 3'd3, 4'd9);
    endtask

    task automatic t_bus_drive();
        expect_drive("R10", 1'b1);
        rd_en_n = 1'b1; #0.5;
        expect_drive("R10", 1'b0);
        rd_en_n = 1'b0; #0.5;
        expect_drive("R10", 1'b1);
        begin_sec(4'd12, 32'hDEADBEEF); wr_all_n = 1'b0; #0.5;
        expect_drive("R10", 1'b0);
        tick();
        expect_state("R10", 3'd2, 4'd12);
        expect_drive("R10", 1'b0);
        idle(); tick();
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_global_write();
        t_byte_write();
        t_primary_ignores_write();
        t_deselect();
        t_burst_write();
        t_burst_read();
        t_hold();
        t_bus_drive();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule